// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources for a small processor core, ranks them under two priority levels and presents one request line with a 16-bit vector address. Two external pins, both active low, can each be set to level or falling-edge operation. Two timer overflow strobes each set a flag. Receive and transmit strobes from a serial port set two flags that share one source. A third timer's overflow strobe and a gated falling-edge input on an auxiliary pin also share one source.

The core raises `vec_ack` for one cycle when it takes the presented vector, and raises `reti` for one cycle when a service routine returns. Some flags are cleared by hardware when their vector is taken. The serial and third-timer flags are cleared only by software, through `flag_clr`. Two in-service bits record which levels are being serviced, so that a high-priority request can preempt a low-priority routine and all other nesting is blocked.

Top module: `intc2l`

## Requirements
- R1: Among requests that may be taken at the same level, the lowest source index wins. The order is: ext0 (0), timer0 (1), ext1 (2), timer1 (3), serial (4), timer2/aux (5). A request at high level is always chosen over one at low level.
- R2: While `irq` is 1, `vec_addr` is 0x0003 + 8 × source index, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R3: With its type bit set to 1, an external pin sets its flag (flags[0] for ext0, flags[2] for ext1) once for each high-to-low transition. Taking that vector clears the flag, and a pin that stays low does not set it again.
- R4: With its type bit set to 0, an external flag follows the low level of the synchronized pin. Taking the vector does not clear it, so a pin that is held low requests again after `reti`.
- R5: A timer overflow strobe sets flags[1] (timer0) or flags[3] (timer1). Taking that source's vector clears the flag, unless a new strobe arrives in the same cycle.
- R6: The serial source requests while flags[4] (receive) or flags[5] (transmit) is 1. Taking its vector leaves both flags unchanged. A 1 on the matching bit of `flag_clr` clears a flag.
- R7: The timer2 source requests while flags[6] (overflow) or flags[7] (aux edge) is 1. Taking its vector clears neither flag, and only `flag_clr` does.
- R8: A falling edge on `aux_n` sets flags[7] only while `aux_en` is 1. An edge seen while `aux_en` is 0 leaves the flag at 0.
- R9: A high-priority request may preempt a low-priority routine. A low-priority request is not taken while any routine is in service, and a high-priority request is not taken while a high-priority routine is in service.
- R10: `reti` clears the high in-service bit if it is set, and otherwise clears the low in-service bit. One return therefore leaves an interrupted low-priority routine still in service.
- R11: A source can be taken only while `glb_en` and its bit of `src_en` are both 1. Its flag stays pending while it is disabled and is taken once it is enabled.
- R12: After reset all flags are 0, `irq` is 0 and `vec_addr` is 0. `vec_addr` is 0 whenever `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| ext0_edge | input | 1 | Type bit for ext0: 1 selects falling edge, 0 selects low level |
| ext1_edge | input | 1 | Type bit for ext1: 1 selects falling edge, 0 selects low level |
| tmr0_ovf | input | 1 | Timer0 overflow strobe |
| tmr1_ovf | input | 1 | Timer1 overflow strobe |
| tmr2_ovf | input | 1 | Timer2 overflow strobe |
| aux_n | input | 1 | Auxiliary edge pin |
| aux_en | input | 1 | Enables the auxiliary falling-edge detection |
| rx_set | input | 1 | Serial receive-complete strobe |
| tx_set | input | 1 | Serial transmit-complete strobe |
| flag_clr | input | 8 | Software clear, one bit per flag, using the positions of `flags` |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, indexed by source |
| src_hi | input | 6 | Per-source priority, 1 selects high level |
| vec_ack | input | 1 | The core takes the presented vector |
| reti | input | 1 | Return from a service routine |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | Vector address of the selected source |
| flags | output | 8 | Flag bits: ext0, timer0, ext1, timer1, rx, tx, timer2 overflow, aux edge (bit 0 to bit 7) |

## Verification
The hardest situation to reach is a three-deep sequence of in-service states. In it, a high-priority routine blocks a second high-priority request while a preempted low-priority routine still holds a pending low-priority flag. Only this sequence shows that each return unwinds exactly one level. The stimulus builds the sequence in order. It takes a low-priority timer vector, re-strobes that timer so a low request waits, takes a high-priority timer vector, and then drops the ext0 pin with ext0 set to high priority. Each `reti` then reveals a different vector, or no request at all.

// File: rtl/intc2l.sv
module intc2l #(
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int          VEC_STRIDE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext0_n,
  input  logic        ext1_n,
  input  logic        ext0_edge,
  input  logic        ext1_edge,
  input  logic        tmr0_ovf,
  input  logic        tmr1_ovf,
  input  logic        tmr2_ovf,
  input  logic        aux_n,
  input  logic        aux_en,
  input  logic        rx_set,
  input  logic        tx_set,
  input  logic [7:0]  flag_clr,
  input  logic        glb_en,
  input  logic [5:0]  src_en,
  input  logic [5:0]  src_hi,
  input  logic        vec_ack,
  input  logic        reti,
  output logic        irq,
  output logic [15:0] vec_addr,
  output logic [7:0]  flags
);
  localparam int          NSRC     = 6;
  localparam logic [15:0] STRIDE16 = 16'(VEC_STRIDE);

  // [0] first stage, [1] synchronized sample, [2] previous sample
  logic [2:0] x0_q, x1_q, ax_q;
  logic       fall0, fall1, fall_ax;
  logic       ins_hi, ins_lo;
  logic [NSRC-1:0] req, pend, hi_c, lo_c, cand, take_i;
  logic [2:0] sel;
  logic       sel_hi, take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0_q <= 3'b111;
      x1_q <= 3'b111;
      ax_q <= 3'b111;
    end else begin
      x0_q <= {x0_q[1:0], ext0_n};
      x1_q <= {x1_q[1:0], ext1_n};
      ax_q <= {ax_q[1:0], aux_n};
    end
  end

  assign fall0   = x0_q[2] & ~x0_q[1];
  assign fall1   = x1_q[2] & ~x1_q[1];
  assign fall_ax = ax_q[2] & ~ax_q[1];

  assign req  = {flags[6] | flags[7], flags[4] | flags[5], flags[3], flags[2], flags[1], flags[0]};
  assign pend = req & src_en & {NSRC{glb_en}};
  assign hi_c = pend & src_hi & {NSRC{~ins_hi}};
  assign lo_c = pend & ~src_hi & {NSRC{~ins_hi & ~ins_lo}};
  assign sel_hi = |hi_c;
  assign cand = sel_hi ? hi_c : lo_c;
  assign irq  = |cand;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i]) sel = 3'(i);
  end

  assign vec_addr = irq ? VEC_BASE + STRIDE16 * {13'd0, sel} : 16'd0;
  assign take     = vec_ack & irq;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_take
      assign take_i[g] = take && (sel == 3'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags[0] <= ext0_edge ? (fall0 | (flags[0] & ~take_i[0] & ~flag_clr[0])) : ~x0_q[1];
      flags[1] <= tmr0_ovf | (flags[1] & ~take_i[1] & ~flag_clr[1]);
      flags[2] <= ext1_edge ? (fall1 | (flags[2] & ~take_i[2] & ~flag_clr[2])) : ~x1_q[1];
      flags[3] <= tmr1_ovf | (flags[3] & ~take_i[3] & ~flag_clr[3]);
      flags[4] <= rx_set   | (flags[4] & ~flag_clr[4]);
      flags[5] <= tx_set   | (flags[5] & ~flag_clr[5]);
      flags[6] <= tmr2_ovf | (flags[6] & ~flag_clr[6]);
      flags[7] <= (aux_en & fall_ax) | (flags[7] & ~flag_clr[7]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (take) begin
      if (sel_hi) ins_hi <= 1'b1;
      else        ins_lo <= 1'b1;
    end else if (reti) begin
      if (ins_hi) ins_hi <= 1'b0;
      else        ins_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/intc2l_chk.sv
module intc2l_chk #(
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int          VEC_STRIDE = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [15:0] vec_addr,
  input logic        vec_ack,
  input logic        reti,
  input logic        tmr0_ovf,
  input logic [5:0]  src_hi,
  input logic [7:0]  flags,
  input logic [7:0]  flag_clr,
  input logic        ins_hi,
  input logic        ins_lo
);
  localparam logic [15:0] STRIDE16 = 16'(VEC_STRIDE);
  logic [15:0] off, idx;
  assign off = vec_addr - VEC_BASE;
  assign idx = off / STRIDE16;

  // R2
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((off % STRIDE16) == 16'd0 && idx < 16'd6));

  // R12
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> vec_addr == 16'd0);

  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq);

  // R9
  lo_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && irq && idx < 16'd6) |-> src_hi[idx[2:0]]);

  // R5
  tf0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq && vec_addr == VEC_BASE + STRIDE16 && !tmr0_ovf) |=> !flags[1]);

  // R6
  ser_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq && flags[4] && !flag_clr[4]) |=> flags[4]);

  // R10
  reti_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(vec_ack && irq) && ins_hi) |=> (!ins_hi && $stable(ins_lo)));
endmodule

bind intc2l intc2l_chk #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .vec_addr(vec_addr), .vec_ack(vec_ack),
  .reti(reti), .tmr0_ovf(tmr0_ovf), .src_hi(src_hi), .flags(flags),
  .flag_clr(flag_clr), .ins_hi(ins_hi), .ins_lo(ins_lo));

// File: tb/intc2l_test.sv
module intc2l_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext0_n = 1, ext1_n = 1, ext0_edge = 1, ext1_edge = 0;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, aux_n = 1, aux_en = 0;
  logic rx_set = 0, tx_set = 0, glb_en = 0, vec_ack = 0, reti = 0;
  logic [7:0] flag_clr = '0;
  logic [5:0] src_en = '0, src_hi = '0;
  logic irq;
  logic [15:0] vec_addr;
  logic [7:0] flags;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  intc2l uut (.clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .tmr0_ovf(tmr0_ovf),
    .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf), .aux_n(aux_n), .aux_en(aux_en),
    .rx_set(rx_set), .tx_set(tx_set), .flag_clr(flag_clr), .glb_en(glb_en),
    .src_en(src_en), .src_hi(src_hi), .vec_ack(vec_ack), .reti(reti),
    .irq(irq), .vec_addr(vec_addr), .flags(flags));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each taken vector with the scoreboard
  always begin
    @(negedge clk); #1;
    if (vec_ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL unexpected take: actual=%h expected=none", vec_addr);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (!irq || vec_addr !== e) begin
          errs++;
          $display("FAIL %s: actual=%h (irq=%b) expected=%h", t, vec_addr, irq, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk); vec_ack = 1;
    @(negedge clk); vec_ack = 0;
  endtask

  task automatic ret();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: tmr0_ovf = 1; 1: tmr1_ovf = 1; 2: tmr2_ovf = 1; 3: rx_set = 1;
      4: tx_set = 1; default: ;
    endcase
    @(negedge clk);
    {tmr0_ovf, tmr1_ovf, tmr2_ovf, rx_set, tx_set} = '0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    check("R12 reset irq", {15'd0, irq}, 16'd0);
    check("R12 reset flags", {8'd0, flags}, 16'd0);
    check("R12 reset vector", vec_addr, 16'd0);
    rst_n = 1;
    tick(2);
    glb_en = 1; src_en = 6'h3F;

    // R1/R5: two timers at once, low level
    @(negedge clk); tmr0_ovf = 1; tmr1_ovf = 1;
    @(negedge clk); tmr0_ovf = 0; tmr1_ovf = 0;
    take(16'h000B, "R1 timer0 before timer1");
    check("R5 timer0 flag cleared", {15'd0, flags[1]}, 16'd0);
    ret();
    take(16'h001B, "R2 timer1 vector");
    ret();
    check("R5 flags clear", {8'd0, flags}, 16'd0);

    // R6: serial flags stay after vectoring
    strobe(3);
    take(16'h0023, "R6 rx vector");
    ret();
    check("R6 rx flag kept", {15'd0, flags[4]}, 16'd1);
    check("R6 still requesting", vec_addr, 16'h0023);
    clear(8'h10);
    check("R6 sw clear", {15'd0, irq}, 16'd0);
    strobe(4);
    check("R6 tx flag", {15'd0, flags[5]}, 16'd1);
    take(16'h0023, "R6 tx vector");
    ret();
    clear(8'h20);

    // R3: ext0 edge mode
    @(negedge clk); ext0_n = 0;
    tick(4);
    take(16'h0003, "R3 ext0 edge vector");
    check("R3 edge flag cleared", {15'd0, flags[0]}, 16'd0);
    ret();
    tick(2);
    check("R3 held low no retrigger", {15'd0, irq}, 16'd0);
    @(negedge clk); ext0_n = 1;
    tick(4);

    // R4: ext1 level mode
    @(negedge clk); ext1_n = 0;
    tick(4);
    take(16'h0013, "R4 ext1 level vector");
    ret();
    check("R4 level retrigger", vec_addr, 16'h0013);
    @(negedge clk); ext1_n = 1;
    tick(4);
    check("R4 level released", {15'd0, flags[2]}, 16'd0);
    check("R4 no request", {15'd0, irq}, 16'd0);

    // R8/R7: aux edge gated
    @(negedge clk); aux_n = 0;
    tick(4);
    check("R8 aux ignored when disabled", {15'd0, flags[7]}, 16'd0);
    @(negedge clk); aux_n = 1; aux_en = 1;
    tick(4);
    @(negedge clk); aux_n = 0;
    tick(4);
    check("R8 aux flag set", {15'd0, flags[7]}, 16'd1);
    take(16'h002B, "R7 timer2 vector via aux");
    ret();
    check("R7 aux flag kept", {15'd0, flags[7]}, 16'd1);
    clear(8'h80);
    strobe(2);
    check("R7 overflow flag", {15'd0, flags[6]}, 16'd1);
    take(16'h002B, "R7 timer2 overflow vector");
    ret();
    check("R7 overflow kept", {15'd0, flags[6]}, 16'd1);
    clear(8'h40);
    check("R7 cleared by software", {8'd0, flags}, 16'd0);
    @(negedge clk); aux_n = 1;

    // R9/R10: nesting
    src_hi = 6'b001000;
    strobe(0);
    take(16'h000B, "R9 low routine");
    strobe(0);
    check("R9 low cannot nest in low", {15'd0, irq}, 16'd0);
    strobe(1);
    take(16'h001B, "R9 high preempts low");
    @(negedge clk); src_hi = 6'b001001; ext0_n = 0;
    tick(4);
    check("R9 high cannot nest in high", {15'd0, irq}, 16'd0);
    ret();
    check("R10 high cleared first", vec_addr, 16'h0003);
    take(16'h0003, "R10 ext0 high in low");
    ret();
    check("R10 low still in service", {15'd0, irq}, 16'd0);
    ret();
    take(16'h000B, "R10 pending low after unwind");
    ret();
    @(negedge clk); ext0_n = 1;
    tick(4);

    // R11: enables
    @(negedge clk); glb_en = 0;
    strobe(1);
    check("R11 global off no irq", {15'd0, irq}, 16'd0);
    check("R11 flag pending", {15'd0, flags[3]}, 16'd1);
    @(negedge clk); glb_en = 1; src_en = 6'b110111;
    tick(1);
    check("R11 source off no irq", {15'd0, irq}, 16'd0);
    @(negedge clk); src_en = 6'h3F;
    take(16'h001B, "R11 taken after enable");
    ret();
    tick(2);
    check("R12 idle vector", vec_addr, 16'd0);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule